// File: doc/BRIEF.md
# Buffered Timer Compare Channel

This block is one 16-bit compare channel that sits beside a timer/counter. It keeps an active compare word, which an equality comparator checks against the running counter value in every cycle. When the two are equal it drives a match strobe toward a waveform generator and latches a sticky flag that serves as an interrupt request. The counter, the waveform logic and interrupt routing sit outside this block.

Software reaches the compare word over an 8-bit bus. The upper byte is written first and is parked in a temporary byte. Writing the lower byte then commits the whole 16-bit word in one step. A 4-bit mode input decides where that word goes. In the plain counting modes it lands in the active register at once. In the pulse-width modes it lands in a shadow register, and the active register picks it up only at the counter's TOP or BOTTOM event, as the mode selects. This keeps the waveform from seeing a half-updated or mid-period threshold.

Top module: `pwm_cmp_channel`

## Requirements
- R1: After reset the active word, the shadow word, the temporary byte and the flag are all zero, so reads of addresses 0, 1 and 2 return zero and the match strobe is high exactly when the counter is zero.
- R2: A write to address 1 (upper byte) changes only the temporary byte; the words readable at addresses 0 and 1 and the comparator threshold stay as they were.
- R3: A write to address 0 (lower byte) joins the written byte with the temporary byte as {temp, data} and commits all 16 bits in the same clock edge.
- R4: In modes 0, 4 and 12 the shadow path is bypassed: a lower-byte write sets the active word, which reads return, and TOP and BOTTOM strobes have no effect on it.
- R5: In every other mode a lower-byte write goes to the shadow word, which reads return, and the active word (the comparator threshold) keeps its old value until the load event.
- R6: The shadow word is copied into the active word on a TOP strobe in buffered modes other than 8 and 9, and on a BOTTOM strobe in modes 8 and 9; the other strobe is ignored. If a lower-byte write falls in the same cycle as the load event, the active word takes the shadow word's previous value.
- R7: The match strobe is high in a cycle if and only if all 16 bits of the counter input equal the active word.
- R8: The flag is set at the clock edge that ends a cycle in which the match strobe is high, and stays set until cleared.
- R9: Writing address 2 with bit 0 equal to 1 clears the flag; writing it with bit 0 equal to 0 leaves the flag unchanged. A read of address 2 returns the flag in bit 0 and zeros above.
- R10: If a match and a clear happen in the same cycle, the flag ends up set.
- R11: A read of address 1 returns the upper byte of the stored word, never the temporary byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| modeSel | input | 4 | Timer mode; selects direct or shadowed loading and the load event |
| counterVal | input | 16 | Current counter value |
| topEvt | input | 1 | One-cycle strobe when the counter is at TOP |
| bottomEvt | input | 1 | One-cycle strobe when the counter is at BOTTOM |
| busAddr | input | 2 | Byte address: 0 lower byte, 1 upper byte, 2 flag |
| busWrData | input | 8 | Write data |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read enable; read data is zero when low |
| busRdData | output | 8 | Read data, combinational from address |
| matchPulse | output | 1 | Counter equals active word |
| cmpFlag | output | 1 | Sticky compare flag (interrupt request) |

## Verification
The hardest case to reach is a lower-byte write that lands in the same cycle as the load event in a buffered mode. There the active word must take the previous shadow value while the shadow word takes the new one. The bench drives both strobes in one cycle. Because the active word has no read path in buffered modes, the bench then probes the comparator with the old and the new values to tell which one the active word holds. It also sweeps all sixteen modes, checking that the wrong strobe is ignored and the right one loads. It forces a counter match on the same edge as a flag clear.

// File: rtl/pwm_cmp_pkg.sv
package pwm_cmp_pkg;

  // Byte addresses seen on the CPU bus
  localparam logic [1:0] ADDR_LO   = 2'd0;
  localparam logic [1:0] ADDR_HI   = 2'd1;
  localparam logic [1:0] ADDR_FLAG = 2'd2;

  // Strobes handed from control to datapath for one cycle
  typedef struct packed {
    logic tempLoad;    // capture upper byte
    logic bufLoad;     // commit word into shadow
    logic actLoadCpu;  // commit word directly into active
    logic actLoadBuf;  // copy shadow into active
    logic flagClr;     // write-one-to-clear of flag
    logic rdSelBuf;    // reads come from shadow
  } cmpCtrl_t;

endpackage

// File: rtl/pwm_cmp_ctrl.sv
module pwm_cmp_ctrl
  import pwm_cmp_pkg::*;
#(
  parameter int MODE_W = 4,
  parameter int BUS_W  = 8
) (
  input  logic [MODE_W-1:0] modeSel,
  input  logic              topEvt,
  input  logic              bottomEvt,
  input  logic [1:0]        busAddr,
  input  logic [BUS_W-1:0]  busWrData,
  input  logic              busWr,
  output cmpCtrl_t          ctrl
);

  logic shadowOn;
  logic loadAtBottom;
  logic loadEvt;

  // Mode decode: plain counting modes bypass the shadow,
  // dual-slope modes 8 and 9 reload at BOTTOM, the rest at TOP.
  always_comb begin
    shadowOn     = 1'b1;
    loadAtBottom = 1'b0;
    case (modeSel)
      MODE_W'(0), MODE_W'(4), MODE_W'(12): shadowOn = 1'b0;
      MODE_W'(8), MODE_W'(9):              loadAtBottom = 1'b1;
      default: ;
    endcase
  end

  assign loadEvt = loadAtBottom ? bottomEvt : topEvt;

  always_comb begin
    ctrl            = '0;
    ctrl.rdSelBuf   = shadowOn;
    ctrl.tempLoad   = busWr && (busAddr == ADDR_HI);
    ctrl.bufLoad    = busWr && (busAddr == ADDR_LO) && shadowOn;
    ctrl.actLoadCpu = busWr && (busAddr == ADDR_LO) && !shadowOn;
    ctrl.actLoadBuf = shadowOn && loadEvt;
    ctrl.flagClr    = busWr && (busAddr == ADDR_FLAG) && busWrData[0];
  end

endmodule

// File: rtl/pwm_cmp_datapath.sv
module pwm_cmp_datapath
  import pwm_cmp_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  cmpCtrl_t             ctrl,
  input  logic [2*BUS_W-1:0]   counterVal,
  input  logic [1:0]           busAddr,
  input  logic [BUS_W-1:0]     busWrData,
  input  logic                 busRd,
  output logic [BUS_W-1:0]     busRdData,
  output logic                 matchPulse,
  output logic                 cmpFlag
);

  localparam int WORD_W = 2 * BUS_W;
  localparam int LANES  = WORD_W / BUS_W;

  logic [BUS_W-1:0]  tempReg;
  logic [WORD_W-1:0] bufReg;
  logic [WORD_W-1:0] activeReg;
  logic [WORD_W-1:0] cpuWord;
  logic [WORD_W-1:0] rdWord;
  logic [BUS_W-1:0]  laneByte [LANES];

  assign cpuWord = {tempReg, busWrData};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tempReg <= '0;
    else if (ctrl.tempLoad) tempReg <= busWrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bufReg <= '0;
    else if (ctrl.bufLoad) bufReg <= cpuWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) activeReg <= '0;
    else if (ctrl.actLoadCpu) activeReg <= cpuWord;
    else if (ctrl.actLoadBuf) activeReg <= bufReg;
  end

  assign matchPulse = (counterVal == activeReg);

  // Set has priority over the software clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cmpFlag <= 1'b0;
    else if (matchPulse) cmpFlag <= 1'b1;
    else if (ctrl.flagClr) cmpFlag <= 1'b0;
  end

  assign rdWord = ctrl.rdSelBuf ? bufReg : activeReg;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign laneByte[g] = rdWord[g*BUS_W +: BUS_W];
  end

  always_comb begin
    busRdData = '0;
    if (busRd) begin
      case (busAddr)
        ADDR_LO:   busRdData = laneByte[0];
        ADDR_HI:   busRdData = laneByte[LANES-1];
        ADDR_FLAG: busRdData = BUS_W'(cmpFlag);
        default:   busRdData = '0;
      endcase
    end
  end

  // R2
  temp_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.tempLoad |=> $stable(tempReg));

  // R3
  act_direct_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.actLoadCpu |=> activeReg == {$past(tempReg), $past(busWrData)});

  // R5
  act_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ctrl.actLoadCpu || ctrl.actLoadBuf) |=> $stable(activeReg));

  // R6
  act_from_buf_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.actLoadBuf && !ctrl.actLoadCpu) |=> activeReg == $past(bufReg));

  // R8
  flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    matchPulse |=> cmpFlag);

  // R8
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cmpFlag) |-> $past(matchPulse));

  // R9
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.flagClr && !matchPulse) |=> !cmpFlag);

endmodule

// File: rtl/pwm_cmp_channel.sv
module pwm_cmp_channel
  import pwm_cmp_pkg::*;
#(
  parameter int MODE_W = 4,
  parameter int BUS_W  = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [MODE_W-1:0]    modeSel,
  input  logic [2*BUS_W-1:0]   counterVal,
  input  logic                 topEvt,
  input  logic                 bottomEvt,
  input  logic [1:0]           busAddr,
  input  logic [BUS_W-1:0]     busWrData,
  input  logic                 busWr,
  input  logic                 busRd,
  output logic [BUS_W-1:0]     busRdData,
  output logic                 matchPulse,
  output logic                 cmpFlag
);

  cmpCtrl_t ctrl;

  pwm_cmp_ctrl #(.MODE_W(MODE_W), .BUS_W(BUS_W)) u_ctrl (
    .modeSel   (modeSel),
    .topEvt    (topEvt),
    .bottomEvt (bottomEvt),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .busWr     (busWr),
    .ctrl      (ctrl)
  );

  pwm_cmp_datapath #(.BUS_W(BUS_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .counterVal (counterVal),
    .busAddr    (busAddr),
    .busWrData  (busWrData),
    .busRd      (busRd),
    .busRdData  (busRdData),
    .matchPulse (matchPulse),
    .cmpFlag    (cmpFlag)
  );

  // R4
  direct_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ctrl.actLoadCpu && ctrl.bufLoad));

endmodule

// File: tb/sim_pwm_cmp_channel.sv
`timescale 1ns/1ps
module sim_pwm_cmp_channel;

  localparam logic [15:0] IDLE = 16'hFFFF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  modeSel = '0;
  logic [15:0] counterVal = IDLE;
  logic        topEvt = 1'b0, bottomEvt = 1'b0;
  logic [1:0]  busAddr = '0;
  logic [7:0]  busWrData = '0;
  logic        busWr = 1'b0, busRd = 1'b0;
  logic [7:0]  busRdData;
  logic        matchPulse, cmpFlag;

  int checks = 0;
  int errors = 0;
  logic [15:0] expActive = '0, expBuf = '0;
  logic [7:0]  rdVal;

  always #5 clk = ~clk;

  pwm_cmp_channel u0 (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .counterVal(counterVal),
    .topEvt(topEvt), .bottomEvt(bottomEvt), .busAddr(busAddr),
    .busWrData(busWrData), .busWr(busWr), .busRd(busRd),
    .busRdData(busRdData), .matchPulse(matchPulse), .cmpFlag(cmpFlag)
  );

  function automatic bit isShadowed(input logic [3:0] m);
    return !(m == 4'd0 || m == 4'd4 || m == 4'd12);
  endfunction

  function automatic bit loadsAtBottom(input logic [3:0] m);
    return (m == 4'd8 || m == 4'd9);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    #1 d = busRdData;
    busRd = 1'b0;
  endtask

  // Probe comparator with no clock edge while the counter differs from IDLE
  task automatic probeMatch(input logic [15:0] v, input bit exp, input string tag);
    @(negedge clk);
    counterVal = v;
    #1 check(matchPulse == exp, tag, matchPulse, exp);
    counterVal = IDLE;
  endtask

  task automatic pulse(input bit top, input bit bot);
    @(negedge clk);
    topEvt = top; bottomEvt = bot;
    @(negedge clk);
    topEvt = 1'b0; bottomEvt = 1'b0;
  endtask

  task automatic readWord(input string tag, input logic [15:0] exp);
    logic [7:0] lo, hi;
    busRead(2'd0, lo);
    busRead(2'd1, hi);
    check({hi, lo} == exp, tag, {hi, lo}, exp);
  endtask

  initial begin : watchdog
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [15:0] v;
    logic [15:0] vis;
    repeat (3) @(negedge clk);
    // R1 reset state
    busRead(2'd0, rdVal); check(rdVal == 8'h00, "R1 lo", rdVal, 0);
    busRead(2'd1, rdVal); check(rdVal == 8'h00, "R1 hi", rdVal, 0);
    busRead(2'd2, rdVal); check(rdVal == 8'h00, "R1 flag", rdVal, 0);
    @(negedge clk); #1 check(matchPulse == 1'b0, "R1 match idle", matchPulse, 0);
    rstN = 1'b1;
    probeMatch(16'h0000, 1'b1, "R1 active zero");

    // Sweep every mode
    for (int m = 0; m < 16; m++) begin
      modeSel = 4'(m);
      v = (16'(m) * 16'h1111) ^ 16'h5A3C;
      vis = isShadowed(modeSel) ? expBuf : expActive;
      busWrite(2'd1, v[15:8]);
      // R2 and R11: upper-byte write stays in temp
      busRead(2'd1, rdVal); check(rdVal == vis[15:8], "R11 hi not temp", rdVal, vis[15:8]);
      probeMatch(v, expActive == v, "R2 threshold unchanged");
      busWrite(2'd0, v[7:0]);
      if (isShadowed(modeSel)) expBuf = v; else expActive = v;
      vis = isShadowed(modeSel) ? expBuf : expActive;
      readWord("R3 word commit", vis);
      probeMatch(v, expActive == v, isShadowed(modeSel) ? "R5 active held" : "R4 direct load");
      if (isShadowed(modeSel)) begin
        pulse(loadsAtBottom(modeSel), !loadsAtBottom(modeSel));
        probeMatch(v, expActive == v, "R6 wrong event ignored");
        pulse(!loadsAtBottom(modeSel), loadsAtBottom(modeSel));
        expActive = expBuf;
        probeMatch(v, 1'b1, "R6 load on event");
      end else begin
        pulse(1'b1, 1'b1);
        probeMatch(v, 1'b1, "R4 events ignored");
      end
    end

    // R6 collision: low write and load event in one cycle (mode 1, TOP)
    modeSel = 4'd1;
    busWrite(2'd1, 8'h21);
    @(negedge clk);
    busAddr = 2'd0; busWrData = 8'h43; busWr = 1'b1; topEvt = 1'b1;
    @(negedge clk);
    busWr = 1'b0; topEvt = 1'b0;
    expActive = expBuf; expBuf = 16'h2143;
    probeMatch(expActive, 1'b1, "R6 collision old shadow");
    probeMatch(16'h2143, 1'b0, "R6 collision new not active");
    readWord("R6 collision shadow", 16'h2143);
    pulse(1'b1, 1'b0);
    expActive = expBuf;
    probeMatch(16'h2143, 1'b1, "R6 collision later load");

    // R7 exhaustive-ish comparator sweep in direct mode
    modeSel = 4'd0;
    busWrite(2'd1, 8'h00);
    busWrite(2'd0, 8'hF0);
    expActive = 16'h00F0;
    for (int c = 0; c < 512; c++)
      probeMatch(16'(c), 16'(c) == expActive, "R7 equality");
    probeMatch(16'h01F0, 1'b0, "R7 upper bits compared");

    // Flag behaviour
    busWrite(2'd2, 8'h01);
    busRead(2'd2, rdVal); check(rdVal == 8'h00, "R9 flag clear start", rdVal, 0);
    @(negedge clk); counterVal = expActive;
    @(negedge clk); counterVal = IDLE;
    #1 check(cmpFlag == 1'b1, "R8 flag set", cmpFlag, 1);
    repeat (3) @(negedge clk);
    check(cmpFlag == 1'b1, "R8 flag sticky", cmpFlag, 1);
    busWrite(2'd2, 8'hFE);
    #1 check(cmpFlag == 1'b1, "R9 write zero no effect", cmpFlag, 1);
    busWrite(2'd2, 8'h01);
    #1 check(cmpFlag == 1'b0, "R9 write one clears", cmpFlag, 0);
    busRead(2'd2, rdVal); check(rdVal == 8'h00, "R9 flag read", rdVal, 0);
    // R10 set beats clear
    @(negedge clk);
    counterVal = expActive; busAddr = 2'd2; busWrData = 8'h01; busWr = 1'b1;
    @(negedge clk);
    counterVal = IDLE; busWr = 1'b0;
    #1 check(cmpFlag == 1'b1, "R10 set wins", cmpFlag, 1);
    busRead(2'd2, rdVal); check(rdVal == 8'h01, "R9 flag read set", rdVal, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule